// File: doc/BRIEF.md
# Framed Synchronous Serial Slave

This block is the device-side end of a clocked serial link. The link has a frame strobe, a serial clock and one shared data line. The host pulls the strobe low to open a frame and raises it again to close it. Every frame carries two bytes, most significant bit first. The first byte is a header. It holds a fixed sync pattern, a direction bit and a register-select bit. The second byte is the payload. In a write frame the host drives all sixteen bits. In a read frame the host drives only the header. The line then turns around, and the block drives the payload, one bit after each falling serial-clock edge.

All three link inputs are asynchronous to the system clock. They pass through a synchronizer, and edges are found by oversampling, so the serial clock must run well below the system clock. A write is handed to the core only when the strobe closes a frame after exactly sixteen bits. For a read, the block asks the core for a byte right after the header is decoded, then shifts that byte out. A malformed header is flagged, and the rest of that frame is ignored. A frame that closes at the wrong length is reported as aborted. Decoding of the payload is left to the core.

Top module: `sfs_slave`

## Requirements
- R1: After reset, sdo_oe_o and sdo_o are 0, and none of wr_valid_o, rd_req_o, frame_err_o or abort_o pulses while the strobe stays high.
- R2: Header bits are numbered 7 (first sent) down to 0. A header is valid only when bits 7..3 are all 1 and bit 0 is 0. Bit 2 is the direction bit: 1 means read, 0 means write. Bit 1 is the register-select bit: 1 means data, 0 means instruction. Any other header gives exactly one frame_err_o pulse.
- R3: A write frame closed after exactly 16 rising serial-clock edges gives one wr_valid_o pulse after the strobe rises. The pulse carries the payload on wr_data_o and the header's register-select bit on wr_rs_o.
- R4: A frame with a valid header that closes after any other number of rising serial-clock edges gives one abort_o pulse and no wr_valid_o. This covers frames that close during the header, short and long write frames, and short read frames.
- R5: A valid read header gives one rd_req_o pulse, with rd_rs_o equal to the header's register-select bit. The block captures rd_data_i in the clock cycle after that pulse.
- R6: In a read frame, the captured byte's bit 7 is on sdo_o after the first falling serial-clock edge that follows the header. Each later falling edge moves to the next lower bit.
- R7: sdo_oe_o is asserted only in the payload phase of a read frame. It is low during the header, during write frames and during frames with a bad header, and it drops when the strobe rises.
- R8: After a bad header, the remaining bits of the frame are ignored. Closing that frame produces no wr_valid_o, no rd_req_o and no abort_o.
- R9: Serial-clock activity while the strobe is high has no effect. Every falling strobe edge restarts decoding at header bit 7.
- R10: wr_valid_o, rd_req_o, frame_err_o and abort_o are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Synchronous active-low reset |
| stb_i | input | 1 | Frame strobe, low while a frame is open |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Data line as received |
| sdo_o | output | 1 | Data line as driven by the block |
| sdo_oe_o | output | 1 | Output enable for the data line driver |
| wr_valid_o | output | 1 | Pulse: a complete write payload is delivered |
| wr_rs_o | output | 1 | Register select of the delivered write |
| wr_data_o | output | PAY_W | Delivered write payload |
| rd_req_o | output | 1 | Pulse: core must supply a read byte |
| rd_rs_o | output | 1 | Register select of the requested read |
| rd_data_i | input | PAY_W | Read byte from the core, valid the cycle after rd_req_o |
| frame_err_o | output | 1 | Pulse: header sync or trailing bit mismatch |
| abort_o | output | 1 | Pulse: frame closed at the wrong length |

## Verification
Every one of the 256 write payloads is sent once, with the register-select bit alternating. This shows that each payload bit lands in its own position and that the select flag is passed on. All 256 header values are sent as header-only frames. That sweep separates the four valid headers, which end in an abort (and, for reads, a request), from the invalid ones, which end in a framing error. Read frames with 64 different core bytes check the bit order after the line turns around and when the output enable is driven. Frames of 15 and 17 bits, read frames cut short, frames closed during the header, bad headers followed by more bits, and serial-clock toggles while the strobe is high each probe one of the length, abort or ignore rules.

// File: rtl/sfs_pkg.sv
// Package: shared constants and types for the framed serial slave.
// Assumes a fixed 8-bit header: a run of sync ones, direction, select, trailing zero.
package sfs_pkg;
    localparam int HDR_W      = 8;
    localparam int SYNC_W     = 5;
    localparam int HDR_RW_BIT = 2;
    localparam int HDR_RS_BIT = 1;

    localparam int LINE_STB = 0;
    localparam int LINE_SCK = 1;
    localparam int LINE_SDI = 2;
    localparam int LINE_N   = 3;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_HDR   = 3'd1,
        PH_WPAY  = 3'd2,
        PH_RWAIT = 3'd3,
        PH_RPAY  = 3'd4,
        PH_DROP  = 3'd5
    } phase_t;
endpackage

// File: rtl/sfs_sync.sv
// Module: multi-bit level synchronizer.
// Each input bit passes through its own STAGES-deep flop chain.
// Assumes each bit is a slow asynchronous level. Reset loads IDLE_VAL so no false edge follows reset.
module sfs_sync #(
    parameter int               N        = 3,
    parameter int               STAGES   = 2,
    parameter logic [N-1:0]     IDLE_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            // Shift the raw input through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{IDLE_VAL[g]}};
                else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
            end
            assign lvl_o[g] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sfs_edge.sv
// Module: edge detector for one synchronized level.
// Gives combinational rise and fall strobes, each one system clock long.
// Assumes the input is already synchronized. IDLE_VAL must match the synchronizer reset value.
module sfs_edge #(
    parameter logic IDLE_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    // Remember the level from the previous system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE_VAL;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/sfs_frame_ctl.sv
// Module: frame sequencer for the framed serial slave.
// Counts serial-clock edges inside a strobe-framed cycle and decodes the header.
// Collects the write payload and raises the delivery, request, error and abort pulses.
// Assumes the edge strobes come from synchronized signals and that sdi_i shares their delay.
module sfs_frame_ctl
    import sfs_pkg::*;
#(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_rise_i,
    input  logic             stb_fall_i,
    input  logic             sck_rise_i,
    input  logic             sck_fall_i,
    input  logic             sdi_i,
    output logic             wr_valid_o,
    output logic [PAY_W-1:0] wr_data_o,
    output logic             rs_o,
    output logic             rd_req_o,
    output logic             frame_err_o,
    output logic             abort_o,
    output logic             oe_o,
    output logic             tx_shift_o,
    output logic [$clog2(HDR_W+PAY_W+2)-1:0] bit_cnt_o
);
    localparam int FRAME_BITS = HDR_W + PAY_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);

    phase_t             phase_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [HDR_W-2:0]   hdr_q;
    logic [PAY_W-1:0]   pay_q;
    logic               rs_q;
    logic               oe_q;
    logic               wr_valid_q;
    logic [PAY_W-1:0]   wr_data_q;
    logic               rd_req_q;
    logic               err_q;
    logic               abort_q;

    logic [HDR_W-1:0]   hdr_next;
    logic               hdr_ok;
    logic [CNT_W-1:0]   cnt_inc;
    logic               frame_done;

    // Header as it stands once the current bit is taken in.
    assign hdr_next = {hdr_q, sdi_i};
    // Valid header: all sync bits set and the trailing bit clear.
    assign hdr_ok   = (hdr_next[HDR_W-1 -: SYNC_W] == {SYNC_W{1'b1}}) && !hdr_next[0];
    // Bit counter that sticks one past a full frame.
    assign cnt_inc  = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
    // A frame is complete when exactly the full number of bits was clocked.
    assign frame_done = (cnt_q == CNT_FULL);

    // Frame phase sequencing, shifting and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            cnt_q      <= '0;
            hdr_q      <= '0;
            pay_q      <= '0;
            rs_q       <= 1'b0;
            oe_q       <= 1'b0;
            wr_valid_q <= 1'b0;
            wr_data_q  <= '0;
            rd_req_q   <= 1'b0;
            err_q      <= 1'b0;
            abort_q    <= 1'b0;
        end else begin
            wr_valid_q <= 1'b0;
            rd_req_q   <= 1'b0;
            err_q      <= 1'b0;
            abort_q    <= 1'b0;
            if (stb_fall_i) begin
                phase_q <= PH_HDR;
                cnt_q   <= '0;
                oe_q    <= 1'b0;
            end else if (stb_rise_i) begin
                if (phase_q == PH_WPAY && frame_done) begin
                    wr_valid_q <= 1'b1;
                    wr_data_q  <= pay_q;
                end else if (phase_q != PH_IDLE && phase_q != PH_DROP &&
                             !(phase_q == PH_RPAY && frame_done)) begin
                    abort_q <= 1'b1;
                end
                phase_q <= PH_IDLE;
                oe_q    <= 1'b0;
            end else begin
                case (phase_q)
                    PH_HDR: begin
                        if (sck_rise_i) begin
                            hdr_q <= hdr_next[HDR_W-2:0];
                            cnt_q <= cnt_inc;
                            if (cnt_q == HDR_LAST) begin
                                rs_q <= hdr_next[HDR_RS_BIT];
                                if (!hdr_ok) begin
                                    phase_q <= PH_DROP;
                                    err_q   <= 1'b1;
                                end else if (hdr_next[HDR_RW_BIT]) begin
                                    phase_q  <= PH_RWAIT;
                                    rd_req_q <= 1'b1;
                                end else begin
                                    phase_q <= PH_WPAY;
                                end
                            end
                        end
                    end
                    PH_WPAY: begin
                        if (sck_rise_i) begin
                            pay_q <= {pay_q[PAY_W-2:0], sdi_i};
                            cnt_q <= cnt_inc;
                        end
                    end
                    PH_RWAIT: begin
                        if (sck_fall_i) begin
                            phase_q <= PH_RPAY;
                            oe_q    <= 1'b1;
                        end
                    end
                    PH_RPAY: begin
                        if (sck_rise_i) cnt_q <= cnt_inc;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Advance the transmit byte on each falling serial clock of the read payload.
    assign tx_shift_o = (phase_q == PH_RPAY) && sck_fall_i && !stb_rise_i && !stb_fall_i;

    assign wr_valid_o  = wr_valid_q;
    assign wr_data_o   = wr_data_q;
    assign rs_o        = rs_q;
    assign rd_req_o    = rd_req_q;
    assign frame_err_o = err_q;
    assign abort_o     = abort_q;
    assign oe_o        = oe_q;
    assign bit_cnt_o   = cnt_q;
endmodule

// File: rtl/sfs_tx_shift.sv
// Module: transmit shifter for read payloads.
// Captures the core byte one cycle after the request and presents it MSB first.
// Assumes the core holds data_i valid in the cycle after load_i.
module sfs_tx_shift #(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PAY_W-1:0] data_i,
    input  logic             shift_i,
    output logic             msb_o
);
    logic             load_q;
    logic [PAY_W-1:0] sh_q;

    // Delay the request by one cycle to line up with the core's reply.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= load_i;
    end

    // Load the reply, or move the next lower bit into the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_q <= '0;
        else if (load_q)  sh_q <= data_i;
        else if (shift_i) sh_q <= {sh_q[PAY_W-2:0], 1'b0};
    end

    assign msb_o = sh_q[PAY_W-1];
endmodule

// File: rtl/sfs_slave.sv
// Module: framed synchronous serial slave (top).
// Oversamples the strobe, serial clock and data line with clk and decodes the two-byte frames.
// Delivers writes to the core and shifts out the bytes the core returns for reads.
// Assumes the serial clock phases last several clk periods longer than SYNC_STAGES.
module sfs_slave
    import sfs_pkg::*;
#(
    parameter int PAY_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             sck_i,
    input  logic             sdi_i,
    output logic             sdo_o,
    output logic             sdo_oe_o,
    output logic             wr_valid_o,
    output logic             wr_rs_o,
    output logic [PAY_W-1:0] wr_data_o,
    output logic             rd_req_o,
    output logic             rd_rs_o,
    input  logic [PAY_W-1:0] rd_data_i,
    output logic             frame_err_o,
    output logic             abort_o
);
    localparam int CNT_W = $clog2(HDR_W + PAY_W + 2);
    localparam logic [LINE_N-1:0] LINE_IDLE = LINE_N'(1 << LINE_STB);
    localparam int EDGE_N = 2;

    logic [LINE_N-1:0] line_lvl;
    logic [EDGE_N-1:0] edge_rise;
    logic [EDGE_N-1:0] edge_fall;
    logic              stb_lvl;
    logic              stb_rise;
    logic              rs_w;
    logic              oe_w;
    logic              tx_shift;
    logic              tx_msb;
    logic [CNT_W-1:0]  bit_cnt;

    sfs_sync #(
        .N        (LINE_N),
        .STAGES   (SYNC_STAGES),
        .IDLE_VAL (LINE_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi_i, sck_i, stb_i}),
        .lvl_o   (line_lvl)
    );

    genvar g;
    generate
        for (g = 0; g < EDGE_N; g++) begin : g_edge
            sfs_edge #(
                .IDLE_VAL (LINE_IDLE[g])
            ) u_edge (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (line_lvl[g]),
                .rise_o (edge_rise[g]),
                .fall_o (edge_fall[g])
            );
        end
    endgenerate

    assign stb_lvl  = line_lvl[LINE_STB];
    assign stb_rise = edge_rise[LINE_STB];

    sfs_frame_ctl #(
        .PAY_W (PAY_W)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_rise_i  (stb_rise),
        .stb_fall_i  (edge_fall[LINE_STB]),
        .sck_rise_i  (edge_rise[LINE_SCK]),
        .sck_fall_i  (edge_fall[LINE_SCK]),
        .sdi_i       (line_lvl[LINE_SDI]),
        .wr_valid_o  (wr_valid_o),
        .wr_data_o   (wr_data_o),
        .rs_o        (rs_w),
        .rd_req_o    (rd_req_o),
        .frame_err_o (frame_err_o),
        .abort_o     (abort_o),
        .oe_o        (oe_w),
        .tx_shift_o  (tx_shift),
        .bit_cnt_o   (bit_cnt)
    );

    sfs_tx_shift #(
        .PAY_W (PAY_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (rd_req_o),
        .data_i  (rd_data_i),
        .shift_i (tx_shift),
        .msb_o   (tx_msb)
    );

    assign wr_rs_o  = rs_w;
    assign rd_rs_o  = rs_w;
    assign sdo_oe_o = oe_w;
    assign sdo_o    = oe_w & tx_msb;
endmodule

// File: rtl/sfs_slave_chk.sv
// Module: property checker for the framed serial slave, bound to the top.
// Assumes access to the synchronized strobe level, its rise strobe and the frame bit counter.
module sfs_slave_chk #(
    parameter int CNT_W = 5,
    parameter int HDR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stb_lvl,
    input logic             stb_rise,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             sdo_oe_o,
    input logic             wr_valid_o,
    input logic             rd_req_o,
    input logic             frame_err_o,
    input logic             abort_o
);
    localparam logic [CNT_W-1:0] HDR_CNT = CNT_W'(HDR_W);

    p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);
    p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);
    p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o);
    p_abort_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);
    p_wr_on_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> $past(stb_rise));
    p_wr_not_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid_o && abort_o));
    p_err_at_header_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> (bit_cnt == HDR_CNT));
    p_req_at_header_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (bit_cnt == HDR_CNT) && !frame_err_o);
    p_oe_after_header_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_o |-> (bit_cnt >= HDR_CNT));
    p_oe_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_lvl && $past(stb_lvl)) |-> !sdo_oe_o);
    p_idle_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_lvl && $past(stb_lvl)) |-> $stable(bit_cnt));
endmodule

bind sfs_slave sfs_slave_chk #(
    .CNT_W (CNT_W),
    .HDR_W (sfs_pkg::HDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb_lvl     (stb_lvl),
    .stb_rise    (stb_rise),
    .bit_cnt     (bit_cnt),
    .sdo_oe_o    (sdo_oe_o),
    .wr_valid_o  (wr_valid_o),
    .rd_req_o    (rd_req_o),
    .frame_err_o (frame_err_o),
    .abort_o     (abort_o)
);

// File: tb/sfs_slave_tb.sv
module sfs_slave_tb;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic [7:0] rd_byte = 8'h00;

    logic       sdo, sdo_oe, wr_valid, wr_rs, rd_req, rd_rs, frame_err, abort_p;
    logic [7:0] wr_data;

    int checks = 0;
    int fails  = 0;
    int n_wr = 0, n_req = 0, n_err = 0, n_abort = 0, n_oe = 0, n_dbl = 0;
    logic [7:0] last_wr_data = 8'h00;
    logic       last_wr_rs = 1'b0, last_req_rs = 1'b0;
    logic       p_wr = 1'b0, p_req = 1'b0, p_err = 1'b0, p_ab = 1'b0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    sfs_slave u_dut (
        .clk (clk), .rst_n (rst_n), .stb_i (stb), .sck_i (sck), .sdi_i (sdi),
        .sdo_o (sdo), .sdo_oe_o (sdo_oe), .wr_valid_o (wr_valid), .wr_rs_o (wr_rs),
        .wr_data_o (wr_data), .rd_req_o (rd_req), .rd_rs_o (rd_rs),
        .rd_data_i (rd_byte), .frame_err_o (frame_err), .abort_o (abort_p)
    );

    // Event monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (wr_valid) begin n_wr++; last_wr_data = wr_data; last_wr_rs = wr_rs; end
        if (rd_req) begin n_req++; last_req_rs = rd_rs; end
        if (frame_err) n_err++;
        if (abort_p) n_abort++;
        if (sdo_oe) n_oe++;
        if ((wr_valid && p_wr) || (rd_req && p_req) || (frame_err && p_err) || (abort_p && p_ab)) n_dbl++;
        p_wr = wr_valid; p_req = rd_req; p_err = frame_err; p_ab = abort_p;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic bit_of(input logic [7:0] hdr, input logic [7:0] pay, input int i);
        if (i < 8)  return hdr[7-i];
        if (i < 16) return pay[15-i];
        return 1'b0;
    endfunction

    // One strobe-framed cycle; samples the data line just before each payload rising edge.
    task automatic frame(input logic [7:0] hdr, input logic [7:0] pay, input int nbits,
                         output logic [7:0] rx, output int oe_hdr_bad, output int oe_miss);
        rx = 8'h00; oe_hdr_bad = 0; oe_miss = 0;
        stb = 1'b0;
        wait_clk(H);
        for (int i = 0; i < nbits; i++) begin
            sdi = bit_of(hdr, pay, i);
            if (i == 8) wait_clk(2 * H);
            wait_clk(H);
            if (i < 8 && sdo_oe) oe_hdr_bad++;
            if (i >= 8 && i < 16) begin
                rx[15-i] = sdo;
                if (!sdo_oe) oe_miss++;
            end
            sck = 1'b1;
            wait_clk(H);
            sck = 1'b0;
        end
        wait_clk(H);
        stb = 1'b1;
        wait_clk(12);
    endtask

    initial begin
        logic [7:0] rx;
        int hb, om, w0, q0, e0, a0, o0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(10);
        // R1: idle state after reset
        chk(sdo_oe == 1'b0 && sdo == 1'b0, "R1 line released after reset", {sdo_oe, sdo}, 0);
        chk(n_wr + n_req + n_err + n_abort == 0, "R1 no pulses after reset", n_wr + n_req + n_err + n_abort, 0);

        // R3 / R7: full write sweep, select bit follows payload bit 0
        for (int p = 0; p < 256; p++) begin
            logic rs;
            rs = p[0];
            w0 = n_wr; a0 = n_abort; o0 = n_oe;
            frame({5'h1F, 1'b0, rs, 1'b0}, 8'(p), 16, rx, hb, om);
            chk(n_wr == w0 + 1 && last_wr_data == 8'(p) && last_wr_rs == rs,
                "R3 write delivery", {last_wr_rs, last_wr_data}, {rs, 8'(p)});
            chk(n_abort == a0 && n_oe == o0, "R7 no drive in write frame", n_oe - o0, 0);
        end

        // R5 / R6 / R7: read sweep with varied core bytes
        for (int i = 0; i < 64; i++) begin
            logic rs;
            rs = i[0];
            rd_byte = 8'(i * 37 + 5);
            q0 = n_req; a0 = n_abort; w0 = n_wr;
            frame({5'h1F, 1'b1, rs, 1'b0}, 8'h00, 16, rx, hb, om);
            chk(rx == rd_byte, "R6 read bits MSB first", rx, rd_byte);
            chk(n_req == q0 + 1 && last_req_rs == rs, "R5 read request", {last_req_rs, 8'(n_req - q0)}, {rs, 8'd1});
            chk(hb == 0 && om == 0 && sdo_oe == 1'b0, "R7 enable only in read payload", {hb[7:0], om[7:0]}, 0);
            chk(n_abort == a0 && n_wr == w0, "R4 complete read no abort", n_abort - a0, 0);
        end

        // R2 / R4: header-only frames over every header value
        for (int h = 0; h < 256; h++) begin
            logic [7:0] hv;
            bit valid;
            hv = 8'(h);
            valid = (hv[7:3] == 5'h1F) && !hv[0];
            w0 = n_wr; q0 = n_req; e0 = n_err; a0 = n_abort;
            frame(hv, 8'h00, 8, rx, hb, om);
            chk(n_err - e0 == (valid ? 0 : 1), "R2 header check", n_err - e0, valid ? 0 : 1);
            chk(n_abort - a0 == (valid ? 1 : 0) && n_wr == w0, "R4 header-only frame aborts", n_abort - a0, valid ? 1 : 0);
            chk(n_req - q0 == ((valid && hv[2]) ? 1 : 0) && sdo_oe == 1'b0, "R5 request only on valid read header",
                n_req - q0, (valid && hv[2]) ? 1 : 0);
        end

        // R4: short and long write frames
        w0 = n_wr; a0 = n_abort;
        frame(8'hFA, 8'h81, 15, rx, hb, om);
        chk(n_wr == w0 && n_abort == a0 + 1, "R4 15-bit write dropped", n_abort - a0, 1);
        w0 = n_wr; a0 = n_abort;
        frame(8'hFA, 8'h81, 17, rx, hb, om);
        chk(n_wr == w0 && n_abort == a0 + 1, "R4 17-bit write dropped", n_abort - a0, 1);

        // R4 / R7: read cut short in the payload
        rd_byte = 8'hC3; a0 = n_abort; o0 = n_oe;
        frame(8'hFC, 8'h00, 12, rx, hb, om);
        chk(n_abort == a0 + 1 && n_oe > o0 && sdo_oe == 1'b0, "R4 short read aborts, R7 enable released",
            {n_abort - a0, 8'(sdo_oe)}, 16'h100);

        // R8: bad headers followed by payload bits
        w0 = n_wr; q0 = n_req; e0 = n_err; a0 = n_abort; o0 = n_oe;
        frame(8'hF9, 8'hFF, 16, rx, hb, om);
        frame(8'h7C, 8'hFF, 16, rx, hb, om);
        chk(n_err == e0 + 2 && n_wr == w0 && n_req == q0 && n_abort == a0 && n_oe == o0,
            "R8 rest of bad frame ignored", {n_wr - w0, n_req - q0, n_abort - a0}, 0);

        // R9: serial clock while strobe high, then restart after a frame cut in the header
        w0 = n_wr; q0 = n_req; e0 = n_err; a0 = n_abort; o0 = n_oe;
        for (int k = 0; k < 20; k++) begin
            sdi = k[1];
            wait_clk(H); sck = 1'b1; wait_clk(H); sck = 1'b0;
        end
        wait_clk(12);
        chk(n_wr == w0 && n_req == q0 && n_err == e0 && n_abort == a0 && n_oe == o0,
            "R9 clock ignored while strobe high", n_wr + n_req + n_err + n_abort - w0 - q0 - e0 - a0, 0);
        frame(8'hFA, 8'h00, 3, rx, hb, om);
        chk(n_abort == a0 + 1, "R9 cut frame aborts", n_abort - a0, 1);
        frame(8'hFA, 8'h3C, 16, rx, hb, om);
        chk(n_wr == w0 + 1 && last_wr_data == 8'h3C && last_wr_rs == 1'b1, "R9 restart at header",
            {last_wr_rs, last_wr_data}, 9'h13C);

        // R10: no pulse ever lasted more than one cycle
        chk(n_dbl == 0, "R10 single-cycle pulses", n_dbl, 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule